// File: doc/BRIEF.md
# Nonvolatile Array Program/Erase Sequencer

This block controls a small on-chip nonvolatile word array, held here as a register array. A bus write to the array never stores data directly. The write is an interlock that starts a hardware sequence. A control register chooses the kind of interlock (program or erase), the erase block mask and the shadow-row select. Once the sequence starts, the block runs timed pulses and checks the target cells with a margin-read after each pulse. It ends with a pass or fail status.

A program interlock captures the word address and a clear mask. The clear mask is built from the write data and the byte enables. The sequence then drives the chosen bits from 1 to 0. An erase interlock ignores its address and data. The erase sets every word of the blocks picked by the control mask back to all ones. Array reads return data one cycle after the request. The shadow-select bit sends reads and programs to a separate four-word shadow row. A test input gives how many pulses a cell needs before it flips, which models a slow or a stuck cell.

Top module: `fe_seq`

## Requirements
- R1: After reset, busy, pass and op_done are 0, and every word of the main array and of the shadow row reads as all ones.
- R2: A program sequence clears exactly those bits whose write data bit is 0 within an enabled byte. A bit that is already 0 stays 0 even when the data bit is 1, and no other word changes.
- R3: bus_be bit k enables byte k, which is bits 8k+7..8k. Byte, half-word and word programming follow from the enable pattern, and bytes that are not enabled keep their contents.
- R4: An erase sequence sets to all ones every word of each block whose bit is set in the control block mask, where the block of a word is address bits 4..2. Words in blocks that are not selected keep their contents.
- R5: An erase interlock write issued while the block mask is all zero does not raise busy. In the next cycle op_done is 1 and pass is 1.
- R6: busy goes high in the cycle after an interlock write. Each pulse lasts 16 cycles and is followed by one verify cycle. A cell that needs N pulses (1 to 64) therefore keeps busy high for 17*N cycles. op_done pulses for one cycle in the cycle where busy falls.
- R7: If the cells have not reached the target after 64 pulses, the sequence ends with busy high for 1088 cycles and pass = 0. The target word is left unchanged.
- R8: pass becomes 1 on a successful sequence. It keeps its value until the next sequence completes.
- R9: While the control shadow bit is 1, reads and program sequences use shadow-row word bus_addr[1:0]. The main array is not touched.
- R10: While busy, a read returns rd_data = 0 with rd_valid = 1. Interlock writes and control writes issued during that time have no effect.
- R11: A read request produces rd_valid and the addressed word in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load control register (ignored while busy) |
| cfg_shadow | input | 1 | Control: route reads/programs to the shadow row |
| cfg_erase | input | 1 | Control: interlock writes start an erase instead of a program |
| cfg_blk_mask | input | 8 | Control: erase block select, one bit per block |
| cell_pulses | input | 7 | Pulses a cell needs before it changes state |
| bus_wr | input | 1 | Interlock write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Program data (0 bits are cleared) |
| bus_be | input | 4 | Byte enables for programming |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| busy | output | 1 | Sequence in progress |
| pass | output | 1 | Status of last completed sequence |
| op_done | output | 1 | One-cycle completion pulse |

## Verification
Some rules are checked by assertions in every cycle. A program pulse never turns a 0 into a 1. A completed erase leaves all of its selected words at ones. A read during busy returns zero. The control register stays frozen while busy. The pulse count never goes past the cap. An empty-mask erase finishes in one cycle with pass set. Every fall of busy comes with op_done, and the timeout branch reports a failure. Other behaviour needs the scoreboard scenarios. These cover the exact data that results from each byte-enable pattern, the sequence length for different pulse counts, isolation between blocks and between the shadow row and the main array, and a write issued during busy that must leave no trace once the sequence is done.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PULSE  = 2'd1,
    ST_VERIFY = 2'd2
  } fe_state_e;
endpackage

// File: rtl/fe_timer.sv
module fe_timer #(
  parameter int PULSE_CYC  = 16,
  parameter int MAX_PULSES = 64,
  localparam int CW = $clog2(PULSE_CYC),
  localparam int PW = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  output logic          pulse_end,
  output logic [PW-1:0] pulse_cnt
);
  logic [CW-1:0] cyc_q, cyc_d;
  logic [PW-1:0] pcnt_q, pcnt_d;

  assign pulse_end = run && (cyc_q == CW'(PULSE_CYC - 1));
  assign pulse_cnt = pcnt_q;

  always_comb begin
    cyc_d  = cyc_q;
    pcnt_d = pcnt_q;
    if (start) begin
      cyc_d  = '0;
      pcnt_d = '0;
    end else if (run) begin
      if (pulse_end) begin
        cyc_d  = '0;
        pcnt_d = pcnt_q + PW'(1);
      end else begin
        cyc_d = cyc_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      pcnt_q <= '0;
    end else if (start || run) begin
      cyc_q  <= cyc_d;
      pcnt_q <= pcnt_d;
    end
  end

  assert_pulse_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= PW'(MAX_PULSES));
endmodule

// File: rtl/fe_array.sv
module fe_array #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int NBLK   = 8,
  parameter int SH_AW  = 2,
  localparam int DEPTH    = 1 << ADDR_W,
  localparam int WPB      = DEPTH / NBLK,
  localparam int SH_DEPTH = 1 << SH_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_shadow,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  input  logic              apply_prog,
  input  logic              apply_erase,
  input  logic              tgt_shadow,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0] clr_mask,
  input  logic [NBLK-1:0]   blk_mask,
  output logic              prog_ok,
  output logic              erase_ok
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [DATA_W-1:0] sh_q  [SH_DEPTH];
  logic [DATA_W-1:0] sh_d  [SH_DEPTH];
  logic [DEPTH-1:0]  word_ok;
  logic [DATA_W-1:0] tgt_word;
  logic              upd;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam int BLK = w / WPB;
    assign mem_d[w] = (apply_erase && blk_mask[BLK]) ? '1 :
                      (apply_prog && !tgt_shadow && tgt_addr == ADDR_W'(w)) ?
                        (mem_q[w] & ~clr_mask) : mem_q[w];
    assign word_ok[w] = !blk_mask[BLK] || (mem_q[w] == '1);
  end

  for (genvar s = 0; s < SH_DEPTH; s++) begin : g_shadow
    assign sh_d[s] = (apply_prog && tgt_shadow && tgt_addr[SH_AW-1:0] == SH_AW'(s)) ?
                       (sh_q[s] & ~clr_mask) : sh_q[s];
  end

  assign upd      = apply_prog || apply_erase;
  assign tgt_word = tgt_shadow ? sh_q[tgt_addr[SH_AW-1:0]] : mem_q[tgt_addr];
  assign prog_ok  = (tgt_word & clr_mask) == '0;
  assign erase_ok = &word_ok;
  assign rd_word  = rd_shadow ? sh_q[rd_addr[SH_AW-1:0]] : mem_q[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
      for (int i = 0; i < SH_DEPTH; i++) sh_q[i] <= '1;
    end else if (upd) begin
      mem_q <= mem_d;
      sh_q  <= sh_d;
    end
  end

  assert_prog_only_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    apply_prog |=> ((tgt_word & ~$past(tgt_word)) == '0));

  assert_erase_fills_R4: assert property (@(posedge clk) disable iff (!rst_n)
    apply_erase |=> erase_ok);
endmodule

// File: rtl/fe_seq.sv
module fe_seq
  import fe_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int NBLK       = 8,
  parameter int SH_AW      = 2,
  parameter int PULSE_CYC  = 16,
  parameter int MAX_PULSES = 64,
  localparam int BE_W = DATA_W / 8,
  localparam int PW   = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_shadow,
  input  logic              cfg_erase,
  input  logic [NBLK-1:0]   cfg_blk_mask,
  input  logic [PW-1:0]     cell_pulses,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [BE_W-1:0]   bus_be,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              pass,
  output logic              op_done
);
  fe_state_e         state_q, state_d;
  logic              ctl_shadow_q, ctl_erase_q;
  logic [NBLK-1:0]   ctl_blk_q;
  logic              lat_shadow_q, lat_erase_q;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [DATA_W-1:0] lat_clr_q, be_mask;
  logic [NBLK-1:0]   lat_blk_q;
  logic              pass_q, pass_d, done_q, done_d;
  logic              rdv_q;
  logic [DATA_W-1:0] rdat_q, rdat_d, rd_word;
  logic              start, latch_en, ctl_en, apply_p, apply_e;
  logic              pulse_end, prog_ok, erase_ok, verify_ok;
  logic [PW-1:0]     pcnt;

  for (genvar b = 0; b < BE_W; b++) begin : g_be
    assign be_mask[8*b +: 8] = {8{bus_be[b]}};
  end

  assign busy      = (state_q != ST_IDLE);
  assign ctl_en    = cfg_wr && !busy;
  assign verify_ok = lat_erase_q ? erase_ok : prog_ok;

  fe_timer #(.PULSE_CYC(PULSE_CYC), .MAX_PULSES(MAX_PULSES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .run(state_q == ST_PULSE),
    .pulse_end(pulse_end), .pulse_cnt(pcnt)
  );

  fe_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NBLK(NBLK), .SH_AW(SH_AW)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_shadow(ctl_shadow_q), .rd_addr(bus_addr), .rd_word(rd_word),
    .apply_prog(apply_p), .apply_erase(apply_e),
    .tgt_shadow(lat_shadow_q), .tgt_addr(lat_addr_q), .clr_mask(lat_clr_q),
    .blk_mask(lat_blk_q), .prog_ok(prog_ok), .erase_ok(erase_ok)
  );

  always_comb begin
    state_d  = state_q;
    pass_d   = pass_q;
    done_d   = 1'b0;
    start    = 1'b0;
    latch_en = 1'b0;
    apply_p  = 1'b0;
    apply_e  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (bus_wr) begin
          if (ctl_erase_q && ctl_blk_q == '0) begin
            done_d = 1'b1;
            pass_d = 1'b1;
          end else begin
            latch_en = 1'b1;
            start    = 1'b1;
            state_d  = ST_PULSE;
          end
        end
      end
      ST_PULSE: begin
        if (pulse_end) begin
          state_d = ST_VERIFY;
          if ((pcnt + PW'(1)) >= cell_pulses) begin
            apply_p = !lat_erase_q;
            apply_e = lat_erase_q;
          end
        end
      end
      ST_VERIFY: begin
        if (verify_ok) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          pass_d  = 1'b1;
        end else if (pcnt == PW'(MAX_PULSES)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          pass_d  = 1'b0;
        end else begin
          state_d = ST_PULSE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign rdat_d = (bus_rd && !busy) ? rd_word : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pass_q  <= 1'b0;
      done_q  <= 1'b0;
      rdv_q   <= 1'b0;
      rdat_q  <= '0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
      done_q  <= done_d;
      rdv_q   <= bus_rd;
      rdat_q  <= rdat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_shadow_q <= 1'b0;
      ctl_erase_q  <= 1'b0;
      ctl_blk_q    <= '0;
    end else if (ctl_en) begin
      ctl_shadow_q <= cfg_shadow;
      ctl_erase_q  <= cfg_erase;
      ctl_blk_q    <= cfg_blk_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_shadow_q <= 1'b0;
      lat_erase_q  <= 1'b0;
      lat_addr_q   <= '0;
      lat_clr_q    <= '0;
      lat_blk_q    <= '0;
    end else if (latch_en) begin
      lat_shadow_q <= ctl_shadow_q;
      lat_erase_q  <= ctl_erase_q;
      lat_addr_q   <= bus_addr;
      lat_clr_q    <= ~bus_wdata & be_mask;
      lat_blk_q    <= ctl_blk_q;
    end
  end

  assign rd_valid = rdv_q;
  assign rd_data  = rdat_q;
  assign pass     = pass_q;
  assign op_done  = done_q;

  assert_busy_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && busy) |=> (rd_valid && rd_data == '0));

  assert_ctl_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(ctl_blk_q) && $stable(ctl_shadow_q) && $stable(ctl_erase_q)));

  assert_zero_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_wr && ctl_erase_q && ctl_blk_q == '0) |=> (op_done && pass && !busy));

  assert_done_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> op_done);

  assert_timeout_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VERIFY && !verify_ok && pcnt == PW'(MAX_PULSES)) |=> (op_done && !pass));
endmodule

// File: tb/tb_fe_seq.sv
module tb_fe_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, cfg_shadow, cfg_erase;
  logic [7:0]  cfg_blk_mask;
  logic [6:0]  cell_pulses;
  logic        bus_wr, bus_rd;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_be;
  logic        rd_valid, busy, pass, op_done;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  fe_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_shadow(cfg_shadow),
    .cfg_erase(cfg_erase), .cfg_blk_mask(cfg_blk_mask), .cell_pulses(cell_pulses),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .pass(pass), .op_done(op_done)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as rd_valid appears
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11: unexpected read data %h expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_cfg(bit sh, bit er, logic [7:0] m);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_shadow = sh; cfg_erase = er; cfg_blk_mask = m;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_wr(logic [4:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] e, string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_seq(logic [4:0] a, logic [31:0] d, logic [3:0] be,
                         int exp_cyc, bit exp_pass, string t);
    int n;
    do_wr(a, d, be);
    wait_idle(n);
    chk(n == exp_cyc, {t, " busy length"}, n, exp_cyc);
    chk(op_done == 1'b1, {t, " op_done"}, op_done, 1);
    chk(pass == exp_pass, {t, " pass"}, pass, exp_pass);
  endtask

  initial begin
    int n;
    rst_n = 1'b0;
    cfg_wr = 0; cfg_shadow = 0; cfg_erase = 0; cfg_blk_mask = 0;
    cell_pulses = 7'd2;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; bus_be = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(pass == 0, "R1 pass", pass, 0);
    chk(op_done == 0, "R1 op_done", op_done, 0);
    rd(5'd0, 32'hFFFF_FFFF, "R1/R11 word0");
    rd(5'd31, 32'hFFFF_FFFF, "R1 word31");

    // Word program, N=2 pulses
    run_seq(5'd5, 32'h1234_5678, 4'hF, 34, 1'b1, "R6 program N=2");
    rd(5'd5, 32'h1234_5678, "R2 word program");
    rd(5'd4, 32'hFFFF_FFFF, "R2 neighbour untouched");
    // Attempt to set bits: only clearing happens
    run_seq(5'd5, 32'hFFFF_0000, 4'hF, 34, 1'b1, "R2 reprogram");
    rd(5'd5, 32'h1234_0000, "R2 no 0-to-1");
    // Byte and half-word programming
    run_seq(5'd9, 32'h0000_00AA, 4'b0001, 34, 1'b1, "R3 byte");
    rd(5'd9, 32'hFFFF_FFAA, "R3 byte result");
    cell_pulses = 7'd3;
    run_seq(5'd10, 32'h0000_1234, 4'b1100, 51, 1'b1, "R6 halfword N=3");
    rd(5'd10, 32'h0000_FFFF, "R3 halfword result");
    cell_pulses = 7'd2;
    // Erase block 1 (words 4..7)
    do_cfg(1'b0, 1'b1, 8'h02);
    run_seq(5'd0, 32'h0, 4'h0, 34, 1'b1, "R4 erase");
    rd(5'd5, 32'hFFFF_FFFF, "R4 erased word");
    rd(5'd9, 32'hFFFF_FFAA, "R4 other block kept");
    rd(5'd10, 32'h0000_FFFF, "R4 other block kept");
    // Timeout
    do_cfg(1'b0, 1'b0, 8'h00);
    cell_pulses = 7'd100;
    run_seq(5'd12, 32'h0, 4'hF, 1088, 1'b0, "R7 timeout");
    rd(5'd12, 32'hFFFF_FFFF, "R7 word unchanged");
    cell_pulses = 7'd2;
    // Empty-mask erase
    do_cfg(1'b0, 1'b1, 8'h00);
    do_wr(5'd3, 32'h0, 4'hF);
    chk(op_done == 1, "R5 op_done", op_done, 1);
    chk(pass == 1, "R5 pass", pass, 1);
    chk(busy == 0, "R5 busy", busy, 0);
    @(negedge clk);
    chk(busy == 0, "R5 busy stays low", busy, 0);
    chk(pass == 1, "R8 pass held", pass, 1);
    // Shadow row
    do_cfg(1'b1, 1'b0, 8'h00);
    run_seq(5'd2, 32'h0F0F_0F0F, 4'hF, 34, 1'b1, "R9 shadow program");
    rd(5'd2, 32'h0F0F_0F0F, "R9 shadow read");
    rd(5'd1, 32'hFFFF_FFFF, "R9 other shadow word");
    do_cfg(1'b0, 1'b0, 8'h00);
    rd(5'd2, 32'hFFFF_FFFF, "R9 main word untouched");
    // Activity while busy
    do_wr(5'd20, 32'h0, 4'hF);
    rd(5'd9, 32'h0, "R10 read while busy");
    do_wr(5'd21, 32'h0, 4'hF);
    do_cfg(1'b1, 1'b1, 8'hFF);
    wait_idle(n);
    chk(pass == 1, "R10 sequence pass", pass, 1);
    rd(5'd20, 32'h0, "R10 programmed word");
    rd(5'd21, 32'hFFFF_FFFF, "R10 write during busy ignored");
    rd(5'd9, 32'hFFFF_FFAA, "R10 cfg during busy ignored");
    chk(pass == 1, "R8 pass after reads", pass, 1);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule